// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block releases an I2C bus that a slave is holding after losing track of a transfer. A single-cycle start request begins a fixed sequence. First a no-acknowledge phase, during which the block tells the main controller to override its acknowledge and leaves both lines released. Next come nine SCL clock pulses. Last comes a STOP condition. The block drives the lines through open-drain enables: an enable of 1 pulls the line low, and 0 releases it to the pull-up.

Every phase lasts one half period of HALF_US microseconds. The length of a microsecond is taken from a cycles-per-microsecond input, which the block samples when the sequence starts. A busy flag covers the whole sequence and a one-cycle done pulse marks its end. Deciding that the bus is stuck, counting retries and re-initialising the main controller all belong to the logic around this block.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, force_nack_o, busy_o and done_o are all 0.
- R2: When start_i is sampled high while idle, busy_o rises at that edge. The first phase lasts P = HALF_US * C cycles, where C is the sampled cycles_per_us_i. In this phase force_nack_o is 1 and scl_oe_o and sda_oe_o are 0.
- R3: After the acknowledge phase, exactly NUM_PULSES (default 9) SCL pulses follow. Each pulse is a low phase (scl_oe_o=1) and then a high phase (scl_oe_o=0), each lasting P cycles. During the pulses sda_oe_o stays 0 and force_nack_o stays 1.
- R4: After the last high phase comes the STOP. For P cycles scl_oe_o=1 and sda_oe_o=1. Then for P cycles scl_oe_o=0 and sda_oe_o=1. Then SDA is released while SCL is high. force_nack_o is 0 throughout the STOP.
- R5: busy_o stays high without a gap for (2*NUM_PULSES+3)*P cycles. done_o is high for exactly one cycle, starting at the edge where busy_o falls.
- R6: A start_i pulse while busy_o is high has no effect on the sequence or its length.
- R7: cycles_per_us_i is sampled only when a start is accepted. Changing it during a sequence does not alter any phase length.
- R8: A sampled cycles_per_us_i of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start a bus clear |
| cycles_per_us_i | input | CPU_W | System clock cycles per microsecond |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| force_nack_o | output | 1 | Tells the controller to give a no-acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The hardest cases to reach from the ports are disturbances in the middle of a sequence: a second start, or a new microsecond count, arriving while the pulse train is already running. The expected outcome is that nothing changes, and that only shows up in the exact length of every later phase. For each run the bench records every output segment of the triple {force_nack, scl_oe, sda_oe} and its length. It injects the disturbance three phases into the sequence. It then compares all 21 segments, the total busy time and the done pulse with values computed from the sampled count.

// File: rtl/i2c_bus_clear_pkg.sv
package i2c_bus_clear_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NACK,
    ST_LO,
    ST_HI,
    ST_STOP_LO,
    ST_STOP_HI
  } bc_state_e;
endpackage

// File: rtl/bc_phase_timer.sv
module bc_phase_timer #(
  parameter int CPU_W   = 8,
  parameter int HALF_US = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CPU_W-1:0] cpu_i,
  output logic             end_o
);
  localparam int US_W = $clog2(HALF_US + 1);

  logic [CPU_W-1:0] cyc_q;
  logic [US_W-1:0]  us_q;
  logic             us_tick;

  assign us_tick = (cyc_q == cpu_i - 1'b1);
  assign end_o   = run_i && us_tick && (us_q == US_W'(HALF_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      us_q  <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
      us_q  <= '0;
    end else if (us_tick) begin
      cyc_q <= '0;
      us_q  <= (us_q == US_W'(HALF_US - 1)) ? '0 : us_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assert_cyc_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cyc_q < cpu_i));
  assert_us_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    us_q < US_W'(HALF_US));
endmodule

// File: rtl/bc_pulse_count.sv
module bc_pulse_count #(
  parameter int NUM_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(NUM_PULSES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= CNT_W'(NUM_PULSES);
    else if (step_i) cnt_q <= cnt_q - 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_PULSES));
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q != '0));
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bus_clear_pkg::*;
#(
  parameter int CPU_W      = 8,
  parameter int HALF_US    = 20,
  parameter int NUM_PULSES = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CPU_W-1:0] cycles_per_us_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             force_nack_o,
  output logic             busy_o,
  output logic             done_o
);
  bc_state_e        state_q, state_d;
  logic [CPU_W-1:0] cpu_q;
  logic             accept, phase_end, last_pulse, step, done_q;

  assign accept = start_i && (state_q == ST_IDLE);
  assign step   = phase_end && (state_q == ST_HI);

  always_comb begin
    state_d = state_q;
    if (accept) state_d = ST_NACK;
    else if (phase_end) begin
      unique case (state_q)
        ST_NACK:    state_d = ST_LO;
        ST_LO:      state_d = ST_HI;
        ST_HI:      state_d = last_pulse ? ST_STOP_LO : ST_LO;
        ST_STOP_LO: state_d = ST_STOP_HI;
        ST_STOP_HI: state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cpu_q   <= CPU_W'(1);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= phase_end && (state_q == ST_STOP_HI);
      if (accept) cpu_q <= (cycles_per_us_i == '0) ? CPU_W'(1) : cycles_per_us_i;
    end
  end

  bc_phase_timer #(.CPU_W(CPU_W), .HALF_US(HALF_US)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .cpu_i  (cpu_q),
    .end_o  (phase_end)
  );

  bc_pulse_count #(.NUM_PULSES(NUM_PULSES)) pulses_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .step_i (step),
    .last_o (last_pulse)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign scl_oe_o     = (state_q == ST_LO) || (state_q == ST_STOP_LO);
  assign sda_oe_o     = (state_q == ST_STOP_LO) || (state_q == ST_STOP_HI);
  assign force_nack_o = (state_q == ST_NACK) || (state_q == ST_LO) || (state_q == ST_HI);
  assign done_o       = done_q;

  assert_done_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_fall_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_sda_low_under_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> scl_oe_o);
  assert_stop_release_scl_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> (!scl_oe_o && !busy_o));
  assert_start_first_nack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (force_nack_o && !scl_oe_o && !sda_oe_o));
  assert_cpu_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cpu_q));
endmodule

// File: tb/i2c_bus_clear_tb_top.sv
module i2c_bus_clear_tb_top;
  localparam int CPU_W = 8;
  localparam int HALF_US = 20;
  localparam int NP = 9;
  localparam int NSEG = 2 * NP + 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CPU_W-1:0] cpu = '0;
  logic scl_oe, sda_oe, nack, busy, done;
  int n_chk = 0, n_fail = 0;

  always #2.5ns clk = ~clk;

  i2c_bus_clear #(.CPU_W(CPU_W), .HALF_US(HALF_US), .NUM_PULSES(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cycles_per_us_i(cpu),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .force_nack_o(nack),
    .busy_o(busy), .done_o(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({scl_oe, sda_oe, nack, busy, done} == 5'b0, "R1", "outputs after reset",
        int'({scl_oe, sda_oe, nack, busy, done}), 0);
    repeat (5) @(negedge clk);
    chk({scl_oe, sda_oe, nack, busy, done} == 5'b0, "R1", "outputs idle",
        int'({scl_oe, sda_oe, nack, busy, done}), 0);
  endtask

  // poke: 0 none, 1 start while busy (R6), 2 change cycles_per_us (R7)
  task automatic run_clear(input int c, input int poke, input string req);
    logic [2:0] seg_v [0:63];
    int seg_l [0:63];
    int nseg = 0, total = 0, p, bad;
    p = HALF_US * ((c == 0) ? 1 : c);
    @(negedge clk);
    cpu = CPU_W'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && nack && !scl_oe && !sda_oe, "R2", "state after start",
        int'({busy, nack, scl_oe, sda_oe}), 4'b1100);
    while (busy && total < 100000) begin
      logic [2:0] cur;
      cur = {nack, scl_oe, sda_oe};
      if (nseg == 0 || cur != seg_v[nseg-1]) begin
        if (nseg < 64) begin
          seg_v[nseg] = cur;
          seg_l[nseg] = 1;
        end
        nseg++;
      end else if (nseg <= 64) seg_l[nseg-1]++;
      total++;
      if (total == 3 * p) begin
        if (poke == 1) start = 1'b1;
        if (poke == 2) cpu = CPU_W'(c + 3);
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R5", "done at busy fall", int'(done), 1);
    chk(total == NSEG * p, {req, " busy length"}, "R5", total, NSEG * p);
    chk(nseg == NSEG, {req, " segment count"}, "R3", nseg, NSEG);
    if (nseg == NSEG) begin
      chk(seg_v[0] == 3'b100 && seg_l[0] == p, "R2", "nack phase length",
          seg_l[0], p);
      bad = 0;
      for (int i = 1; i <= 2 * NP; i++) begin
        logic [2:0] e;
        e = (i % 2 == 1) ? 3'b110 : 3'b100;
        if (seg_v[i] != e || seg_l[i] != p) bad++;
      end
      chk(bad == 0, "R3", {req, " pulse phases wrong"}, bad, 0);
      chk(seg_v[NSEG-2] == 3'b011 && seg_l[NSEG-2] == p, "R4", "stop setup",
          seg_l[NSEG-2], p);
      chk(seg_v[NSEG-1] == 3'b001 && seg_l[NSEG-1] == p, "R4", "stop hold",
          seg_l[NSEG-1], p);
    end
    @(negedge clk);
    chk(!done && !busy && !sda_oe && !scl_oe, "R5", "done one cycle",
        int'({done, busy, sda_oe, scl_oe}), 0);
  endtask

  initial begin
    #(150000 * 5ns);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_clear(2, 0, "R3 cpu2");
    run_clear(1, 0, "R3 cpu1");
    run_clear(0, 0, "R8 cpu0");
    run_clear(2, 1, "R6 restart");
    run_clear(3, 2, "R7 cpu change");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule